// File: doc/BRIEF.md
# Smart-Card Slot Session Sequencer

This block is the digital controller for one contact smart-card slot. It watches a supply-good comparator and keeps the card interface inactive for a fixed hold-off time after the supply rises. It filters the card-presence inputs, which may be wired either active-high or active-low, and reports card status to the host on an active-low status/interrupt line. When the host requests a session, it powers the card contacts in a fixed order. When the session ends, it takes them down in the reverse order.

All durations are counted in cycles of a single reference clock and set by parameters. With a 1 MHz reference, the defaults give a 220-cycle supply hold-off, an 8000-cycle presence filter, 27-cycle sequencing steps (81 cycles to activate and 81 to deactivate) and a one-cycle reset delay. The block only produces enable and select levels. A separate analog stage acts on the card supply voltage code, the I/O release, the clock gate and the card reset level. A fault input from that stage, or the card being pulled out, ends a live session at once.

When the block is idle and the session request, 5 V select and 1.8 V select inputs are all high, it reports a low-power stop condition. The host then gates off the rest of the slot.

Top module: `card_slot_sequencer`

## Requirements
- R1: After `supply_ok` rises, `vcc_en` stays low for HOLD_CYC cycles. If presence is already filtered, the block is armed and a request is pending, `vcc_en` rises exactly HOLD_CYC+1 cycles after the rise.
- R2: If `supply_ok` falls during a session, `card_rst` drops on the next cycle while `vcc_en` stays high. The full deactivation order of R9 then runs to completion.
- R3: The card counts as present when `pres_hi` is 1 or `pres_lo_n` is 0. A change in raw presence reaches `irq_n` only after it has held for DEB_CYC consecutive cycles, and it appears exactly DEB_CYC cycles after the change. Shorter excursions are ignored.
- R4: When no alarm is pending, `irq_n` is 1 for a card that is present and filtered, and 0 when no card is present.
- R5: Activation raises `vcc_en`, then `io_en` STEP_CYC cycles later, then `clk_en` STEP_CYC cycles after that. At all times `io_en` implies `vcc_en`, `clk_en` implies `io_en`, and `card_rst` implies `clk_en`.
- R6: `vcc_sel` is 2'b01 (1.8 V) when `sel_1v8` is 1. Otherwise it is 2'b11 (5 V) when `sel_5v` is 1, or 2'b10 (3 V) when `sel_5v` is 0. It reads 2'b00 whenever `vcc_en` is 0. The code is captured on the cycle activation starts and holds for the whole session.
- R7: `stop_mode` is 1 exactly when the block is idle (`vcc_en` low) and `sess_req_n`, `sel_5v` and `sel_1v8` are all 1.
- R8: After activation completes, `card_rst` equals `host_rst` delayed by RST_DLY cycles. In every other phase `card_rst` is 0.
- R9: When `sess_req_n` returns high during a session, `card_rst` drops on the next cycle. `clk_en` falls STEP_CYC cycles after that, `io_en` falls STEP_CYC cycles after `clk_en`, and `vcc_en` falls STEP_CYC cycles after `io_en`.
- R10: If `fault` is 1, or raw presence is lost, during activation or a live session, deactivation begins on the next cycle (`card_rst` low) and `irq_n` goes low. `irq_n` stays low until the block is idle and `sess_req_n` is 1.
- R11: After reset or after any deactivation, a new session starts only once `sess_req_n` has been seen high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Digital supply above threshold |
| pres_hi | input | 1 | Presence switch, high = card |
| pres_lo_n | input | 1 | Presence switch, low = card |
| sess_req_n | input | 1 | Host session request, active low |
| sel_5v | input | 1 | 1 = 5 V, 0 = 3 V card |
| sel_1v8 | input | 1 | 1 = 1.8 V card, overrides sel_5v |
| host_rst | input | 1 | Host card-reset level |
| fault | input | 1 | Analog-stage fault, forces deactivation |
| irq_n | output | 1 | Status/interrupt, active low |
| vcc_en | output | 1 | Card supply enable |
| vcc_sel | output | 2 | Card supply code (00 off, 01 1.8 V, 10 3 V, 11 5 V) |
| io_en | output | 1 | Card I/O released (0 = held low) |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset level |
| stop_mode | output | 1 | Low-power stop condition |

## Verification
The assertions assume all inputs are synchronous to `clk` and change only between edges. They also assume `fault` and presence loss are real events rather than glitches the block should filter. The bench drives every input one nanosecond after a rising edge and samples the outputs later in the cycle. Its random phase toggles each input with a low per-cycle probability, which leaves sessions time to complete while still letting aborts land in every activation and deactivation step. Supply loss is kept rare so that hold-off periods do not dominate the run.

// File: rtl/cslot_pkg.sv
package cslot_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PWR    = 3'd1,
    SQ_IOREL  = 3'd2,
    SQ_CLKON  = 3'd3,
    SQ_LIVE   = 3'd4,
    SQ_RSTLO  = 3'd5,
    SQ_CLKOFF = 3'd6,
    SQ_IOLO   = 3'd7
  } seq_st_t;

  localparam logic [1:0] VC_OFF = 2'b00;
  localparam logic [1:0] VC_1V8 = 2'b01;
  localparam logic [1:0] VC_3V  = 2'b10;
  localparam logic [1:0] VC_5V  = 2'b11;

  // Supply code: the 1.8 V select wins over the 5 V / 3 V select.
  function automatic logic [1:0] pick_vcode(input logic hi5, input logic v18);
    if (v18) return VC_1V8;
    if (hi5) return VC_5V;
    return VC_3V;
  endfunction

  function automatic logic stop_code(input logic req_n, input logic hi5, input logic v18);
    return req_n & hi5 & v18;
  endfunction

  // Counter width able to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cslot_holdoff.sv
module cslot_holdoff
  import cslot_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 220
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  output logic ready
);
  localparam int unsigned   HW   = cw(HOLD_CYC + 1);
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC);

  logic [HW-1:0] cnt;

  // Restart on every supply dip; saturate once the hold-off has elapsed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!supply_ok) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + HW'(1);
  end

  assign ready = supply_ok && (cnt == LAST);

endmodule

// File: rtl/cslot_presence.sv
module cslot_presence
  import cslot_pkg::*;
#(
  parameter int unsigned DEB_CYC = 8000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pres_hi,
  input  logic pres_lo_n,
  output logic raw_present,
  output logic present_db
);
  localparam int unsigned   DW   = cw(DEB_CYC);
  localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

  logic [DW-1:0] cnt;

  assign raw_present = pres_hi | ~pres_lo_n;

  // The filtered level moves only after the raw level has differed from it
  // for DEB_CYC consecutive cycles; any return to agreement restarts the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      present_db <= 1'b0;
    end else if (raw_present == present_db) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt        <= '0;
      present_db <= raw_present;
    end else begin
      cnt <= cnt + DW'(1);
    end
  end

endmodule

// File: rtl/cslot_seq.sv
module cslot_seq
  import cslot_pkg::*;
#(
  parameter int unsigned STEP_CYC = 27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       raw_present,
  input  logic       present_db,
  input  logic       sess_req_n,
  input  logic       sel_5v,
  input  logic       sel_1v8,
  input  logic       fault,
  input  logic       host_rst_d,
  output logic       vcc_en,
  output logic [1:0] vcc_sel,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       stop_mode,
  output logic       alarm,
  output logic       sess_on,
  output logic       live
);
  localparam int unsigned   SW   = cw(STEP_CYC);
  localparam logic [SW-1:0] LAST = SW'(STEP_CYC - 1);

  seq_st_t       st, nxt;
  logic [SW-1:0] step_cnt;
  logic          step_done;
  logic          armed;
  logic          start;
  logic          forced;
  logic          abort;
  logic [1:0]    vsel_q;

  assign step_done = (step_cnt == LAST);
  assign sess_on   = (st == SQ_PWR) || (st == SQ_IOREL) || (st == SQ_CLKON) || (st == SQ_LIVE);
  assign live      = (st == SQ_LIVE);
  assign forced    = fault || !raw_present;
  assign abort     = sess_req_n || !ready || forced;
  assign start     = (st == SQ_IDLE) && armed && ready && present_db && raw_present &&
                     !sess_req_n && !fault;

  always_comb begin
    nxt = st;
    case (st)
      SQ_IDLE:   if (start) nxt = SQ_PWR;
      SQ_PWR:    if (abort) nxt = SQ_RSTLO; else if (step_done) nxt = SQ_IOREL;
      SQ_IOREL:  if (abort) nxt = SQ_RSTLO; else if (step_done) nxt = SQ_CLKON;
      SQ_CLKON:  if (abort) nxt = SQ_RSTLO; else if (step_done) nxt = SQ_LIVE;
      SQ_LIVE:   if (abort) nxt = SQ_RSTLO;
      SQ_RSTLO:  if (step_done) nxt = SQ_CLKOFF;
      SQ_CLKOFF: if (step_done) nxt = SQ_IOLO;
      SQ_IOLO:   if (step_done) nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      step_cnt <= '0;
    end else begin
      st <= nxt;
      if (st != nxt)       step_cnt <= '0;
      else if (!step_done) step_cnt <= step_cnt + SW'(1);
    end
  end

  // Contact enables: each is set on entry to its activation step and
  // cleared on entry to its deactivation step, so an abort part-way
  // through activation never turns anything on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcc_en <= 1'b0;
      io_en  <= 1'b0;
      clk_en <= 1'b0;
    end else begin
      vcc_en <= (nxt != SQ_IDLE);
      if (nxt == SQ_IOREL)
        io_en <= 1'b1;
      else if ((nxt == SQ_IOLO) || (nxt == SQ_IDLE))
        io_en <= 1'b0;
      if (nxt == SQ_CLKON)
        clk_en <= 1'b1;
      else if ((nxt == SQ_CLKOFF) || (nxt == SQ_IOLO) || (nxt == SQ_IDLE))
        clk_en <= 1'b0;
    end
  end

  // Re-arm only after the request has been released while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             armed <= 1'b0;
    else if (start)                         armed <= 1'b0;
    else if ((st == SQ_IDLE) && sess_req_n) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             alarm <= 1'b0;
    else if (sess_on && forced)             alarm <= 1'b1;
    else if ((st == SQ_IDLE) && sess_req_n) alarm <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vsel_q <= VC_OFF;
    else if (start) vsel_q <= pick_vcode(sel_5v, sel_1v8);
  end

  assign vcc_sel   = vcc_en ? vsel_q : VC_OFF;
  assign card_rst  = live && host_rst_d;
  assign stop_mode = (st == SQ_IDLE) && stop_code(sess_req_n, sel_5v, sel_1v8);

endmodule

// File: rtl/card_slot_sequencer.sv
module card_slot_sequencer
  import cslot_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 220,
  parameter int unsigned DEB_CYC  = 8000,
  parameter int unsigned STEP_CYC = 27,
  parameter int unsigned RST_DLY  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       pres_hi,
  input  logic       pres_lo_n,
  input  logic       sess_req_n,
  input  logic       sel_5v,
  input  logic       sel_1v8,
  input  logic       host_rst,
  input  logic       fault,
  output logic       irq_n,
  output logic       vcc_en,
  output logic [1:0] vcc_sel,
  output logic       io_en,
  output logic       clk_en,
  output logic       card_rst,
  output logic       stop_mode
);
  // Named internal events, visible to the bound checker.
  logic ready;
  logic raw_present;
  logic present_db;
  logic alarm;
  logic sess_on;
  logic live;
  logic host_rst_d;

  cslot_holdoff #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk       (clk),
    .rst_n     (rst_n),
    .supply_ok (supply_ok),
    .ready     (ready)
  );

  cslot_presence #(.DEB_CYC(DEB_CYC)) u_presence (
    .clk         (clk),
    .rst_n       (rst_n),
    .pres_hi     (pres_hi),
    .pres_lo_n   (pres_lo_n),
    .raw_present (raw_present),
    .present_db  (present_db)
  );

  generate
    if (RST_DLY == 0) begin : g_rst_direct
      assign host_rst_d = host_rst;
    end else begin : g_rst_pipe
      logic [RST_DLY-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe <= '0;
        end else begin
          pipe[0] <= host_rst;
          for (int i = 1; i < RST_DLY; i++) pipe[i] <= pipe[i-1];
        end
      end
      assign host_rst_d = pipe[RST_DLY-1];
    end
  endgenerate

  cslot_seq #(.STEP_CYC(STEP_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .raw_present (raw_present),
    .present_db  (present_db),
    .sess_req_n  (sess_req_n),
    .sel_5v      (sel_5v),
    .sel_1v8     (sel_1v8),
    .fault       (fault),
    .host_rst_d  (host_rst_d),
    .vcc_en      (vcc_en),
    .vcc_sel     (vcc_sel),
    .io_en       (io_en),
    .clk_en      (clk_en),
    .card_rst    (card_rst),
    .stop_mode   (stop_mode),
    .alarm       (alarm),
    .sess_on     (sess_on),
    .live        (live)
  );

  assign irq_n = present_db && !alarm;

endmodule

// File: rtl/cslot_checker.sv
module cslot_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       fault,
  input logic       ready,
  input logic       raw_present,
  input logic       present_db,
  input logic       sess_on,
  input logic       live,
  input logic       vcc_en,
  input logic [1:0] vcc_sel,
  input logic       io_en,
  input logic       clk_en,
  input logic       card_rst,
  input logic       stop_mode,
  input logic       irq_n
);
  a_r1_power_after_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(ready));

  a_r2_supply_loss_drops_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !supply_ok) |=> (!card_rst && vcc_en));

  a_r3_filter_takes_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(present_db) |-> (present_db == $past(raw_present)));

  a_r5_io_needs_vcc: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  a_r5_clk_needs_io: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  a_r5_rst_needs_clk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);

  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && $past(vcc_en)) |-> $stable(vcc_sel));

  a_r6_code_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_en |-> (vcc_sel == 2'b00));

  a_r7_stop_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |-> !vcc_en);

  a_r10_fault_drops_rst: assert property (@(posedge clk) disable iff (!rst_n)
    (live && fault) |=> !card_rst);

  a_r10_fault_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sess_on && fault) |=> !irq_n);

endmodule

bind card_slot_sequencer cslot_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_ok   (supply_ok),
  .fault       (fault),
  .ready       (ready),
  .raw_present (raw_present),
  .present_db  (present_db),
  .sess_on     (sess_on),
  .live        (live),
  .vcc_en      (vcc_en),
  .vcc_sel     (vcc_sel),
  .io_en       (io_en),
  .clk_en      (clk_en),
  .card_rst    (card_rst),
  .stop_mode   (stop_mode),
  .irq_n       (irq_n)
);

// File: tb/card_slot_sequencer_bench.sv
`timescale 1ns/1ps
module card_slot_sequencer_bench;
  localparam int HOLD = 30;
  localparam int DEB  = 40;
  localparam int STEP = 6;
  localparam int RDLY = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic       pres_hi = 1'b0;
  logic       pres_lo_n = 1'b1;
  logic       sess_req_n = 1'b1;
  logic       sel_5v = 1'b1;
  logic       sel_1v8 = 1'b0;
  logic       host_rst = 1'b0;
  logic       fault = 1'b0;
  logic       irq_n, vcc_en, io_en, clk_en, card_rst, stop_mode;
  logic [1:0] vcc_sel;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int p;

  always #2.5 clk = ~clk;

  card_slot_sequencer #(.HOLD_CYC(HOLD), .DEB_CYC(DEB), .STEP_CYC(STEP), .RST_DLY(RDLY))
  u_card_slot_sequencer (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .pres_hi(pres_hi),
    .pres_lo_n(pres_lo_n), .sess_req_n(sess_req_n), .sel_5v(sel_5v),
    .sel_1v8(sel_1v8), .host_rst(host_rst), .fault(fault), .irq_n(irq_n),
    .vcc_en(vcc_en), .vcc_sel(vcc_sel), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .stop_mode(stop_mode)
  );

  function automatic logic [1:0] exp_code(input logic hi5, input logic v18);
    return v18 ? 2'b01 : {1'b1, ~hi5 ? 1'b0 : 1'b1};
  endfunction

  function automatic logic exp_stop(input logic pwr, input logic rq, input logic h, input logic v);
    return !pwr && rq && h && v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Inputs as seen at each rising edge (drives happen 1 ns after it).
  logic e_hi5, e_v18;
  always @(posedge clk) begin
    e_hi5 = sel_5v;
    e_v18 = sel_1v8;
    cyc <= cyc + 1;
  end

  // Edge recorder and per-cycle invariants, sampled mid-cycle.
  int t_vcc_rise, t_io_rise, t_clk_rise, t_vcc_fall, t_io_fall, t_clk_fall, t_rst_fall;
  logic p_vcc = 0, p_io = 0, p_clk = 0, p_rst = 0;
  logic [1:0] code_q = 2'b00;
  always @(negedge clk) begin
    if (rst_n) begin
      if (vcc_en && !p_vcc) begin t_vcc_rise = cyc; code_q = exp_code(e_hi5, e_v18); end
      if (!vcc_en && p_vcc) t_vcc_fall = cyc;
      if (io_en && !p_io) t_io_rise = cyc;
      if (!io_en && p_io) t_io_fall = cyc;
      if (clk_en && !p_clk) t_clk_rise = cyc;
      if (!clk_en && p_clk) t_clk_fall = cyc;
      if (!card_rst && p_rst) t_rst_fall = cyc;
      chk(!io_en || vcc_en, "R5 io_en implies vcc_en", io_en, vcc_en);
      chk(!clk_en || io_en, "R5 clk_en implies io_en", clk_en, io_en);
      chk(!card_rst || clk_en, "R5 card_rst implies clk_en", card_rst, clk_en);
      chk(stop_mode == exp_stop(vcc_en, sess_req_n, sel_5v, sel_1v8), "R7 stop_mode",
          stop_mode, exp_stop(vcc_en, sess_req_n, sel_5v, sel_1v8));
      chk(vcc_sel == (vcc_en ? code_q : 2'b00), "R6 vcc_sel", vcc_sel,
          vcc_en ? code_q : 2'b00);
    end
    p_vcc = vcc_en; p_io = io_en; p_clk = clk_en; p_rst = card_rst;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_live();
    int n = 0;
    while (!clk_en && n < 500) begin tick(1); n++; end
    chk(clk_en, "R5 clock enabled", clk_en, 1);
    tick(STEP + 1);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    tick(5);
    // Reset state
    chk(vcc_en == 0 && io_en == 0 && clk_en == 0 && card_rst == 0, "R5 reset enables",
        {vcc_en, io_en, clk_en, card_rst}, 0);
    chk(irq_n == 0, "R4 no card after reset", irq_n, 0);
    rst_n = 1'b1;
    tick(2);

    // R3: presence through pres_hi, exact filter delay
    pres_hi = 1'b1;
    tick(DEB - 1);
    chk(irq_n == 0, "R3 before filter expiry", irq_n, 0);
    tick(1);
    chk(irq_n == 1, "R3/R4 card reported present", irq_n, 1);

    // R3: short glitch ignored
    pres_hi = 1'b0;
    tick(DEB / 2);
    pres_hi = 1'b1;
    tick(DEB + 5);
    chk(irq_n == 1, "R3 glitch ignored", irq_n, 1);

    // R1: hold-off then activation; R5 spacing; R6 5 V code
    supply_ok = 1'b1;
    sess_req_n = 1'b0;
    p = cyc;
    tick(HOLD);
    chk(vcc_en == 0, "R1 no power during hold-off", vcc_en, 0);
    tick(1);
    chk(vcc_en == 1, "R1 power after hold-off", vcc_en, 1);
    tick(1);
    chk(t_vcc_rise - p == HOLD + 1, "R1 hold-off length", t_vcc_rise - p, HOLD + 1);
    wait_live();
    chk(t_io_rise - t_vcc_rise == STEP, "R5 io after vcc", t_io_rise - t_vcc_rise, STEP);
    chk(t_clk_rise - t_io_rise == STEP, "R5 clk after io", t_clk_rise - t_io_rise, STEP);
    chk(vcc_sel == 2'b11, "R6 5V code", vcc_sel, 3);

    // R8: reset follows host with RDLY cycles
    host_rst = 1'b1;
    tick(RDLY - 1);
    chk(card_rst == 0, "R8 rise delay", card_rst, 0);
    tick(1);
    chk(card_rst == 1, "R8 rise", card_rst, 1);
    host_rst = 1'b0;
    tick(RDLY - 1);
    chk(card_rst == 1, "R8 fall delay", card_rst, 1);
    tick(1);
    chk(card_rst == 0, "R8 fall", card_rst, 0);

    // R9: normal deactivation order
    host_rst = 1'b1;
    tick(RDLY + 1);
    sess_req_n = 1'b1;
    p = cyc;
    tick(1);
    chk(card_rst == 0, "R9 reset dropped first", card_rst, 0);
    tick(3 * STEP + 2);
    chk(t_rst_fall == p + 1, "R9 reset fall cycle", t_rst_fall - p, 1);
    chk(t_clk_fall - t_rst_fall == STEP, "R9 clk stop", t_clk_fall - t_rst_fall, STEP);
    chk(t_io_fall - t_clk_fall == STEP, "R9 io low", t_io_fall - t_clk_fall, STEP);
    chk(t_vcc_fall - t_io_fall == STEP, "R9 vcc off", t_vcc_fall - t_io_fall, STEP);
    chk(irq_n == 1, "R4 present after session", irq_n, 1);
    chk(card_rst == 0, "R8 reset low while idle", card_rst, 0);

    // R6: 1.8 V override and latch; R10 fault; R11 re-arm
    sel_1v8 = 1'b1; sel_5v = 1'b0;
    sess_req_n = 1'b0;
    wait_live();
    chk(vcc_sel == 2'b01, "R6 1.8V code", vcc_sel, 1);
    sel_1v8 = 1'b0;
    tick(2);
    chk(vcc_sel == 2'b01, "R6 code latched", vcc_sel, 1);
    tick(RDLY);
    fault = 1'b1;
    tick(1);
    chk(card_rst == 0, "R10 fault drops reset", card_rst, 0);
    chk(irq_n == 0, "R10 fault interrupt", irq_n, 0);
    tick(3 * STEP + 2);
    chk(vcc_en == 0, "R10 fault deactivates", vcc_en, 0);
    fault = 1'b0;
    tick(4 * STEP);
    chk(vcc_en == 0, "R11 no restart without release", vcc_en, 0);
    chk(irq_n == 0, "R10 interrupt held", irq_n, 0);
    sess_req_n = 1'b1;
    tick(2);
    chk(irq_n == 1, "R10 interrupt cleared on release", irq_n, 1);

    // R6: 3 V code; R10 card removal
    sess_req_n = 1'b0;
    wait_live();
    chk(vcc_sel == 2'b10, "R6 3V code", vcc_sel, 2);
    tick(RDLY);
    pres_hi = 1'b0;
    tick(1);
    chk(card_rst == 0, "R10 removal drops reset", card_rst, 0);
    chk(irq_n == 0, "R10 removal interrupt", irq_n, 0);
    tick(3 * STEP + 2);
    chk(vcc_en == 0, "R10 removal deactivates", vcc_en, 0);
    sess_req_n = 1'b1;
    tick(DEB + 2);
    chk(irq_n == 0, "R4 absent card reported", irq_n, 0);

    // R3: active-low presence input
    pres_lo_n = 1'b0;
    tick(DEB - 1);
    chk(irq_n == 0, "R3 low-polarity before expiry", irq_n, 0);
    tick(1);
    chk(irq_n == 1, "R3 low-polarity present", irq_n, 1);

    // R7: stop encoding
    sel_5v = 1'b1; sel_1v8 = 1'b1;
    tick(1);
    chk(stop_mode == 1, "R7 stop entered", stop_mode, 1);
    sess_req_n = 1'b0;
    tick(1);
    chk(stop_mode == 0, "R7 stop left on request", stop_mode, 0);
    wait_live();
    chk(vcc_sel == 2'b01, "R6 1.8V wins over 5V", vcc_sel, 1);

    // R2: supply loss during session
    host_rst = 1'b1;
    tick(RDLY + 1);
    chk(card_rst == 1, "R8 reset released to card", card_rst, 1);
    supply_ok = 1'b0;
    tick(1);
    chk(card_rst == 0 && vcc_en == 1, "R2 supply loss starts sequence",
        {card_rst, vcc_en}, 1);
    tick(3 * STEP + 2);
    chk(vcc_en == 0, "R2 supply loss completes", vcc_en, 0);
    chk(t_clk_fall - t_rst_fall == STEP && t_io_fall - t_clk_fall == STEP &&
        t_vcc_fall - t_io_fall == STEP, "R2 deactivation order",
        t_vcc_fall - t_rst_fall, 3 * STEP);
    supply_ok = 1'b1;
    sess_req_n = 1'b1;
    tick(HOLD + 5);

    // Random phase: invariants checked every cycle by the recorder
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 99) < 2)   sess_req_n = ~sess_req_n;
      if ($urandom_range(0, 999) < 3)  supply_ok = ~supply_ok;
      if ($urandom_range(0, 99) < 1)   fault = ~fault;
      if ($urandom_range(0, 199) < 1)  pres_lo_n = ~pres_lo_n;
      if ($urandom_range(0, 99) < 2)   sel_5v = ~sel_5v;
      if ($urandom_range(0, 99) < 2)   sel_1v8 = ~sel_1v8;
      if ($urandom_range(0, 99) < 5)   host_rst = ~host_rst;
      tick(1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule